// File: doc/BRIEF.md
# Floating-Point Operate Instruction Decoder

This block takes one 32-bit floating-point operate instruction per strobe and breaks it down for the execution pipeline. Its outputs are an operation code, the precision of each operand, the three register numbers, and a verdict on whether the instruction may run. Two instruction classes are recognised: arithmetic operations and compares. An opcode value that neither class knows is reported as an illegal operation. For a known opcode, each register number is checked against the precision that opcode gives it. A double operand must name an even register and a quad operand a register that is a multiple of four. A compare writes the condition code rather than a register, so its destination field must be zero. When a check fails, the instruction is flagged with an invalid-register trap and the trap-type code 6.

The control is a two-state machine. IDLE holds while no strobe arrives. The edge that samples `in_valid` high moves it to REPORT, or keeps it in REPORT when strobes come back to back. The edge that sees `in_valid` low returns it to IDLE. `out_valid` is high exactly while the machine is in REPORT. All result registers load on the same edge that takes the instruction, so each decode clears the previous trap code.

Top module: `fpop_decoder`

## Requirements
- R1: An instruction belongs to the arithmetic class when `instr & 32'hC1F80000` equals `32'h81A00000`, and to the compare class when it equals `32'h81A80000`. Any other instruction gives `illegal`=1, `op`=0, all precisions 0, `bad_reg`=0 and `trap_type`=0.
- R2: `rs1_idx` is instr[18:14], `rs2_idx` is instr[4:0] and `rd_idx` is instr[29:25]. These are reported for every decode, legal or not. The opcode field is instr[13:5].
- R3: In the arithmetic class the block decodes these opcodes, with precision codes 1 single, 2 double, 3 quad and 0 unused, listed as rs1/rs2/rd:
  - `op`=1 move, opcode 0x001, precisions 0/1/1.
  - `op`=2 negate, opcode 0x005, precisions 0/1/1.
  - `op`=3 absolute value, opcode 0x009, precisions 0/1/1.
  - `op`=4 square root: opcode 0x029, 0x02A or 0x02B for precision 1, 2 or 3 on rs2 and rd, with rs1 0.
  - `op`=5 add: opcode 0x041, 0x042 or 0x043, all three operands at precision 1, 2 or 3.
  - `op`=6 subtract: opcode 0x045, 0x046 or 0x047, precisions as for add.
  - `op`=7 multiply: opcode 0x049, 0x04A or 0x04B, precisions as for add.
  - `op`=8 divide: opcode 0x04D, 0x04E or 0x04F, precisions as for add.
  - `op`=9 widening multiply: opcode 0x069 with precisions 1/1/2, and opcode 0x06E with precisions 2/2/3.
- R4: In the compare class the block decodes these opcodes, with rd precision 0, meaning a condition-code destination:
  - `op`=10 compare: opcode 0x051, 0x052 or 0x053, with precision 1, 2 or 3 on rs1 and rs2.
  - `op`=11 signalling compare: opcode 0x055, 0x056 or 0x057, with precisions as for compare.
  Any other opcode, including a compare opcode in the arithmetic class or an arithmetic opcode in the compare class, gives `illegal`=1.
- R5: A double-precision operand whose register number has bit 0 set is misaligned.
- R6: A quad-precision operand whose register number has either of bits 1:0 set is misaligned.
- R7: A compare whose rd field is nonzero is an invalid-register error on rd.
- R8: A legal instruction with an invalid register gives `bad_reg`=1 and `trap_type`=6. Every other decode gives `bad_reg`=0 and `trap_type`=0, because the trap code is cleared on each decode.
- R9: Operands are checked in the order rs1, rs2, rd. `bad_field` reports the first one that fails: 1 for rs1, 2 for rs2, 3 for rd, and 0 when none fails.
- R10: The results of an instruction taken on a clock edge appear on the following cycle together with `out_valid`=1. Strobes may arrive on back-to-back cycles. `out_valid` is 0 on any cycle after an edge that saw `in_valid`=0.
- R11: While reset is asserted, `out_valid` and every result output are 0.
- R12: An operand at precision 0 is not checked. For example, a square root with an odd rs1 field is still accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| out_valid | output | 1 | Results valid, one cycle after the strobe |
| op | output | 4 | Operation code (R3, R4) |
| prec_rs1 | output | 2 | Precision of rs1 |
| prec_rs2 | output | 2 | Precision of rs2 |
| prec_rd | output | 2 | Precision of rd, 0 for a condition-code destination |
| rs1_idx | output | 5 | First source register number |
| rs2_idx | output | 5 | Second source register number |
| rd_idx | output | 5 | Destination register number |
| illegal | output | 1 | Unrecognised operation |
| bad_reg | output | 1 | Invalid-register trap |
| bad_field | output | 2 | First failing operand |
| trap_type | output | 3 | Trap-type code: 6 on an invalid register, else 0 |

## Verification
Every result is due exactly one cycle after the edge that takes its strobe. The bench drives on the falling edge and, for each instruction, pushes the values worked out from the requirements into a queue. A monitor samples one nanosecond after each falling edge. Whenever `out_valid` is high it pops the oldest entry, so back-to-back strobes are matched in order. A pulse with an empty queue, or an entry left over at the end, is reported as a timing error.

// File: rtl/fpop_dec_pkg.sv
package fpop_dec_pkg;
    localparam int INSN_W   = 32;
    localparam int REG_W    = 5;
    localparam int OPF_W    = 9;
    localparam int OP_W     = 4;
    localparam int TRAP_W   = 3;
    localparam int NUM_ARGS = 3;

    localparam logic [INSN_W-1:0] CLASS_MASK  = 32'hC1F8_0000;
    localparam logic [INSN_W-1:0] CLASS_ARITH = 32'h81A0_0000;
    localparam logic [INSN_W-1:0] CLASS_CMP   = 32'h81A8_0000;
    localparam logic [TRAP_W-1:0] TT_BAD_REG  = 3'd6;

    typedef enum logic [1:0] {PREC_NONE, PREC_SGL, PREC_DBL, PREC_QUAD} prec_e;

    typedef enum logic [1:0] {ARG_NONE, ARG_RS1, ARG_RS2, ARG_RD} arg_e;

    typedef enum logic [OP_W-1:0] {
        OP_NONE = 4'd0, OP_MOV  = 4'd1, OP_NEG  = 4'd2,  OP_ABS  = 4'd3,
        OP_SQRT = 4'd4, OP_ADD  = 4'd5, OP_SUB  = 4'd6,  OP_MUL  = 4'd7,
        OP_DIV  = 4'd8, OP_WMUL = 4'd9, OP_CMP  = 4'd10, OP_CMPX = 4'd11
    } fop_e;

    typedef struct packed {
        fop_e  op;
        prec_e p_rs1;
        prec_e p_rs2;
        prec_e p_rd;
    } opinfo_t;
endpackage

// File: rtl/fpop_opf_table.sv
module fpop_opf_table
    import fpop_dec_pkg::*;
(
    input  logic             is_arith,
    input  logic             is_cmp,
    input  logic [OPF_W-1:0] opf,
    output opinfo_t          info,
    output logic             known
);
    // precision selected by the low two opcode bits for the sized families
    prec_e sized;

    always_comb begin
        unique case (opf[1:0])
            2'd1:    sized = PREC_SGL;
            2'd2:    sized = PREC_DBL;
            2'd3:    sized = PREC_QUAD;
            default: sized = PREC_NONE;
        endcase
    end

    always_comb begin
        info  = '0;
        known = 1'b1;
        if (is_arith) begin
            case (opf)
                9'h001: info = '{OP_MOV, PREC_NONE, PREC_SGL, PREC_SGL};
                9'h005: info = '{OP_NEG, PREC_NONE, PREC_SGL, PREC_SGL};
                9'h009: info = '{OP_ABS, PREC_NONE, PREC_SGL, PREC_SGL};
                9'h029, 9'h02A, 9'h02B:
                        info = '{OP_SQRT, PREC_NONE, sized, sized};
                9'h041, 9'h042, 9'h043:
                        info = '{OP_ADD, sized, sized, sized};
                9'h045, 9'h046, 9'h047:
                        info = '{OP_SUB, sized, sized, sized};
                9'h049, 9'h04A, 9'h04B:
                        info = '{OP_MUL, sized, sized, sized};
                9'h04D, 9'h04E, 9'h04F:
                        info = '{OP_DIV, sized, sized, sized};
                9'h069: info = '{OP_WMUL, PREC_SGL, PREC_SGL, PREC_DBL};
                9'h06E: info = '{OP_WMUL, PREC_DBL, PREC_DBL, PREC_QUAD};
                default: known = 1'b0;
            endcase
        end else if (is_cmp) begin
            case (opf)
                9'h051, 9'h052, 9'h053:
                        info = '{OP_CMP, sized, sized, PREC_NONE};
                9'h055, 9'h056, 9'h057:
                        info = '{OP_CMPX, sized, sized, PREC_NONE};
                default: known = 1'b0;
            endcase
        end else begin
            known = 1'b0;
        end
        if (!known) info = '0;
    end
endmodule

// File: rtl/fpop_reg_align.sv
module fpop_reg_align
    import fpop_dec_pkg::*;
#(
    parameter int REG_BITS = 5,
    parameter bit ALLOW_CC = 1'b0
) (
    input  prec_e               prec,
    input  logic [REG_BITS-1:0] idx,
    output logic                bad
);
    always_comb begin
        unique case (prec)
            PREC_NONE: bad = ALLOW_CC && (idx != '0);
            PREC_SGL:  bad = 1'b0;
            PREC_DBL:  bad = idx[0];
            PREC_QUAD: bad = |idx[1:0];
            default:   bad = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpop_decoder.sv
module fpop_decoder
    import fpop_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] instr,
    output logic              out_valid,
    output logic [OP_W-1:0]   op,
    output logic [1:0]        prec_rs1,
    output logic [1:0]        prec_rs2,
    output logic [1:0]        prec_rd,
    output logic [REG_W-1:0]  rs1_idx,
    output logic [REG_W-1:0]  rs2_idx,
    output logic [REG_W-1:0]  rd_idx,
    output logic              illegal,
    output logic              bad_reg,
    output logic [1:0]        bad_field,
    output logic [TRAP_W-1:0] trap_type
);
    typedef enum logic {ST_IDLE, ST_REPORT} state_e;

    state_e state_q, state_d;

    // ---------------- class and opcode decode ----------------
    logic    is_arith, is_cmp, known;
    opinfo_t info;

    assign is_arith = (instr & CLASS_MASK) == CLASS_ARITH;
    assign is_cmp   = (instr & CLASS_MASK) == CLASS_CMP;

    fpop_opf_table u_table (
        .is_arith (is_arith),
        .is_cmp   (is_cmp),
        .opf      (instr[13:5]),
        .info     (info),
        .known    (known)
    );

    // ---------------- per-operand alignment ----------------
    prec_e            prec_arr [NUM_ARGS];
    logic [REG_W-1:0] idx_arr  [NUM_ARGS];
    logic [NUM_ARGS-1:0] bad_arr;

    assign prec_arr[0] = info.p_rs1;
    assign prec_arr[1] = info.p_rs2;
    assign prec_arr[2] = info.p_rd;
    assign idx_arr[0]  = instr[18:14];
    assign idx_arr[1]  = instr[4:0];
    assign idx_arr[2]  = instr[29:25];

    for (genvar g = 0; g < NUM_ARGS; g++) begin : g_arg
        fpop_reg_align #(
            .REG_BITS (REG_W),
            .ALLOW_CC (g == NUM_ARGS - 1)
        ) u_align (
            .prec (prec_arr[g]),
            .idx  (idx_arr[g]),
            .bad  (bad_arr[g])
        );
    end

    // lowest-numbered failing operand wins
    arg_e first_bad;
    always_comb begin
        first_bad = ARG_NONE;
        for (int k = NUM_ARGS - 1; k >= 0; k--) begin
            if (known && bad_arr[k]) first_bad = arg_e'(k + 1);
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid)  state_d = ST_REPORT;
            ST_REPORT: if (!in_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign out_valid = (state_q == ST_REPORT);

    // ---------------- result registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op        <= '0;
            prec_rs1  <= '0;
            prec_rs2  <= '0;
            prec_rd   <= '0;
            rs1_idx   <= '0;
            rs2_idx   <= '0;
            rd_idx    <= '0;
            illegal   <= 1'b0;
            bad_reg   <= 1'b0;
            bad_field <= '0;
            trap_type <= '0;
        end else if (in_valid) begin
            op        <= info.op;
            prec_rs1  <= info.p_rs1;
            prec_rs2  <= info.p_rs2;
            prec_rd   <= info.p_rd;
            rs1_idx   <= idx_arr[0];
            rs2_idx   <= idx_arr[1];
            rd_idx    <= idx_arr[2];
            illegal   <= !known;
            bad_reg   <= (first_bad != ARG_NONE);
            bad_field <= first_bad;
            trap_type <= (first_bad != ARG_NONE) ? TT_BAD_REG : '0;
        end
    end

    // ---------------- assertions ----------------
    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2
    rs1_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> rs1_idx == $past(instr[18:14]));
    // R8
    trap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && bad_reg) |-> trap_type == TT_BAD_REG);
    // R8
    trap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !bad_reg) |-> trap_type == '0);
    // R4
    illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> (!bad_reg && op == '0));
endmodule

// File: tb/fpop_decoder_test.sv
`timescale 1ns/1ps
module fpop_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        out_valid;
    logic [3:0]  op;
    logic [1:0]  prec_rs1, prec_rs2, prec_rd, bad_field;
    logic [4:0]  rs1_idx, rs2_idx, rd_idx;
    logic        illegal, bad_reg;
    logic [2:0]  trap_type;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fpop_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .out_valid(out_valid), .op(op), .prec_rs1(prec_rs1), .prec_rs2(prec_rs2),
        .prec_rd(prec_rd), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rd_idx(rd_idx),
        .illegal(illegal), .bad_reg(bad_reg), .bad_field(bad_field), .trap_type(trap_type)
    );

    typedef struct packed {
        logic [3:0] op;
        logic [1:0] p1, p2, pd;
        logic [4:0] r1, r2, rd;
        logic       ill, bad;
        logic [1:0] fld;
        logic [2:0] tt;
    } res_t;

    res_t  exp_q [$];
    string tag_q [$];

    function automatic logic [31:0] mk(input bit cmp, input logic [8:0] f,
                                       input logic [4:0] d, input logic [4:0] a,
                                       input logic [4:0] b);
        logic [31:0] base = cmp ? 32'h81A8_0000 : 32'h81A0_0000;
        return base | ({27'd0, d} << 25) | ({27'd0, a} << 14) | ({23'd0, f} << 5) | {27'd0, b};
    endfunction

    function automatic logic misal(input logic [1:0] p, input logic [4:0] r);
        if (p == 2'd2) return r[0];
        if (p == 2'd3) return r[1:0] != 2'd0;
        return 1'b0;
    endfunction

    // expected values from R1..R12
    function automatic res_t model(input logic [31:0] i);
        res_t e = '0;
        logic ar, cm, ok;
        logic [8:0] f = i[13:5];
        logic [1:0] s;
        e.r1 = i[18:14]; e.r2 = i[4:0]; e.rd = i[29:25];
        ar = (i & 32'hC1F8_0000) == 32'h81A0_0000;
        cm = (i & 32'hC1F8_0000) == 32'h81A8_0000;
        s  = f[1:0];
        ok = 1'b1;
        if (ar) begin
            if (f == 9'h001 || f == 9'h005 || f == 9'h009) begin
                e.op = (f == 9'h001) ? 4'd1 : (f == 9'h005) ? 4'd2 : 4'd3;
                e.p2 = 2'd1; e.pd = 2'd1;
            end else if (f >= 9'h029 && f <= 9'h02B) begin
                e.op = 4'd4; e.p2 = s; e.pd = s;
            end else if (f[8:4] == 5'h04 && s != 2'd0 && !(f[3:2] == 2'd0 && 1'b0)) begin
                e.op = 4'd5 + {2'd0, f[3:2]}; e.p1 = s; e.p2 = s; e.pd = s;
            end else if (f == 9'h069) begin
                e.op = 4'd9; e.p1 = 2'd1; e.p2 = 2'd1; e.pd = 2'd2;
            end else if (f == 9'h06E) begin
                e.op = 4'd9; e.p1 = 2'd2; e.p2 = 2'd2; e.pd = 2'd3;
            end else ok = 1'b0;
        end else if (cm) begin
            if ((f >= 9'h051 && f <= 9'h053) || (f >= 9'h055 && f <= 9'h057)) begin
                e.op = f[2] ? 4'd11 : 4'd10; e.p1 = s; e.p2 = s; e.pd = 2'd0;
            end else ok = 1'b0;
        end else ok = 1'b0;
        if (!ok) begin
            e.op = '0; e.p1 = '0; e.p2 = '0; e.pd = '0; e.ill = 1'b1;
            return e;
        end
        if (misal(e.p1, e.r1))      e.fld = 2'd1;
        else if (misal(e.p2, e.r2)) e.fld = 2'd2;
        else if (e.pd == 2'd0 ? (e.rd != 5'd0) : misal(e.pd, e.rd)) e.fld = 2'd3;
        e.bad = (e.fld != 2'd0);
        e.tt  = e.bad ? 3'd6 : 3'd0;
        return e;
    endfunction

    task automatic send(input logic [31:0] i, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        instr    = i;
        exp_q.push_back(model(i));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        #1;
        if (rst_n && out_valid) begin
            res_t act, e;
            string t;
            act = '{op, prec_rs1, prec_rs2, prec_rd, rs1_idx, rs2_idx, rd_idx,
                    illegal, bad_reg, bad_field, trap_type};
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected out_valid: actual %h expected none", act);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (act !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, act, e);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++; // R11
        if ({out_valid, op, illegal, bad_reg, bad_field, trap_type, rd_idx} !== '0) begin
            errors++;
            $display("FAIL R11 reset state: actual %b expected 0",
                     {out_valid, op, illegal, bad_reg, bad_field, trap_type, rd_idx});
        end
        rst_n = 1'b1;
        idle(2);
        // back-to-back burst
        send(mk(0, 9'h041, 5'd3, 5'd5, 5'd7),    "R3 add single");
        send(mk(0, 9'h042, 5'd2, 5'd4, 5'd6),    "R3 add double");
        send(mk(0, 9'h043, 5'd4, 5'd8, 5'd12),   "R3 add quad");
        send(mk(0, 9'h042, 5'd2, 5'd4, 5'd7),    "R5 double rs2 odd");
        send(mk(0, 9'h043, 5'd4, 5'd2, 5'd8),    "R6 quad rs1 misaligned");
        send(mk(0, 9'h047, 5'd6, 5'd8, 5'd12),   "R6 quad rd misaligned");
        send(mk(0, 9'h04B, 5'd1, 5'd1, 5'd1),    "R9 all bad rs1 first");
        send(mk(0, 9'h04F, 5'd2, 5'd4, 5'd3),    "R9 rs2 before rd");
        idle(2);
        send(mk(1, 9'h051, 5'd0, 5'd3, 5'd9),    "R4 compare single");
        send(mk(1, 9'h056, 5'd1, 5'd2, 5'd4),    "R7 compare rd nonzero");
        send(mk(1, 9'h053, 5'd0, 5'd4, 5'd2),    "R6 compare quad rs2");
        send(mk(1, 9'h055, 5'd0, 5'd1, 5'd2),    "R4 signalling compare");
        idle(1);
        send(mk(0, 9'h0FF, 5'd1, 5'd1, 5'd1),    "R4 unknown opcode");
        send(mk(0, 9'h051, 5'd0, 5'd2, 5'd2),    "R4 compare opcode in arith class");
        send(mk(1, 9'h041, 5'd0, 5'd2, 5'd2),    "R4 add opcode in compare class");
        send(32'h0000_0000,                      "R1 foreign class");
        send(mk(0, 9'h041, 5'd3, 5'd5, 5'd7) ^ 32'h0008_0000, "R1 class bit flipped");
        idle(3);
        send(mk(0, 9'h02A, 5'd4, 5'd7, 5'd2),    "R12 sqrt unused rs1");
        send(mk(0, 9'h02B, 5'd8, 5'd1, 5'd5),    "R6 sqrt quad rs2");
        send(mk(0, 9'h069, 5'd2, 5'd3, 5'd5),    "R3 widening single");
        send(mk(0, 9'h069, 5'd3, 5'd3, 5'd5),    "R5 widening rd odd");
        send(mk(0, 9'h06E, 5'd4, 5'd2, 5'd6),    "R3 widening double");
        send(mk(0, 9'h001, 5'd31, 5'd17, 5'd9),  "R2 move fields");
        send(mk(0, 9'h005, 5'd1, 5'd0, 5'd3),    "R3 negate");
        send(mk(0, 9'h009, 5'd2, 5'd0, 5'd4),    "R3 absolute");
        send(mk(0, 9'h046, 5'd10, 5'd12, 5'd14), "R8 trap cleared after good");
        send(mk(0, 9'h049, 5'd1, 5'd2, 5'd3),    "R3 multiply single");
        send(mk(0, 9'h04D, 5'd1, 5'd2, 5'd3),    "R3 divide single");
        idle(4);
        checks++; // R10
        if (out_valid !== 1'b0 || exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10 idle drain: actual valid=%b pending=%0d expected 0/0",
                     out_valid, exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule